// File: doc/BRIEF.md
# Nibble-Encoded Duplex Stream Port

This block is the command engine for a full-duplex streaming sub-mode, intended for real-time serial traffic such as MIDI. A host writes one-byte commands to a write port. It reads results back from a registered readback byte. One command arms a forward, and the next host byte goes to a transmit interface under a valid/ready handshake. Another command reports whether a received byte is waiting.

A third command delivers the waiting byte in two halves. The low nibble comes first and the high nibble second. Each half is shifted into the upper four bits, and the lower four bits are filled with ones. Because of this padding, an encoded payload is never below 0x0F and cannot be mistaken for the 0/1 status answers.

The receive FIFO and the UART lie outside the block. The block sees a pending flag and the head byte, and it returns a one-cycle pop strobe once the high nibble has been presented. A leave command raises a one-cycle exit pulse, which hands control back to the main command loop.

Top module: `nds_stream_port`

## Requirements
- R1: After synchronous reset, `rdback` is 0x00, and `tx_valid`, `rx_pop` and `exit_pulse` are all 0.
- R2: A write of command 0x01 arms a forward. The next host byte, whatever its value (including 0x01 to 0x04), appears on `tx_data` with `tx_valid` high in the cycle after that write. Neither write changes `rdback` or raises `exit_pulse`.
- R3: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` hold steady. A forward byte that arrives while the slot is still unaccepted is dropped, and the original byte is kept.
- R4: Command 0x02 loads `rdback` with 0x01 if `rx_pending` is high and with 0x00 otherwise.
- R5: With a byte pending, the first command 0x03 loads `rdback` with ((byte & 0x0F) << 4) | 0x0F.
- R6: The next command 0x03 loads `rdback` with (byte & 0xF0) | 0x0F. It pulses `rx_pop` for exactly the one cycle after that write. No pop occurs after the first half.
- R7: Command 0x03 with nothing pending and no half delivered loads 0x0F and does not pop.
- R8: `rdback` changes only in the cycle after a host write. Without writes it holds its value.
- R9: Command 0x04 pulses `exit_pulse` for one cycle and leaves `rdback` unchanged. It also restarts nibble delivery, so the next command 0x03 presents a low nibble.
- R10: Any other command value (0x00 and 0x05 to 0xFF) is ignored: `rdback` is unchanged, and there is no transmit, no pop and no exit.
- R11: Every value loaded by command 0x03 has its low four bits set, so it is at least 0x0F (a zero nibble encodes as 0x0F).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_data | input | 8 | Host command or forward byte |
| rx_pending | input | 1 | Receive FIFO holds at least one byte |
| rx_data | input | 8 | Head byte of the receive FIFO |
| rx_pop | output | 1 | One-cycle pop of the receive FIFO head |
| tx_ready | input | 1 | Transmitter accepts `tx_data` this cycle |
| tx_valid | output | 1 | Forward byte waiting for the transmitter |
| tx_data | output | 8 | Forward byte |
| rdback | output | 8 | Registered result read by the host |
| exit_pulse | output | 1 | One-cycle request to leave the sub-mode |

## Verification
Every result is registered, so `rdback`, `rx_pop`, `exit_pulse` and a newly loaded `tx_valid`/`tx_data` are all due on the first clock edge after the host write cycle. The bench drives each write for one cycle starting at a falling edge. It samples all outputs at the following falling edge, which is exactly one rising edge later, and then clears the strobe. Hold behaviour is checked by idling several cycles and sampling again. Transmit acceptance is checked one edge after `tx_ready` rises.

// File: rtl/nds_pkg.sv
package nds_pkg;
  typedef enum logic [2:0] {
    K_NONE,
    K_FWD_ARM,
    K_QUERY,
    K_NIBBLE,
    K_EXIT,
    K_PAYLOAD
  } kind_t;
endpackage

// File: rtl/nds_cmd_decode.sv
module nds_cmd_decode
  import nds_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CMD_FWD  = 1,
  parameter int CMD_QRY  = 2,
  parameter int CMD_NIB  = 3,
  parameter int CMD_EXIT = 4
) (
  input  logic              wr,
  input  logic              armed,
  input  logic [DATA_W-1:0] data,
  output kind_t             kind
);
  always_comb begin
    kind = K_NONE;
    if (wr) begin
      if (armed) kind = K_PAYLOAD;
      else if (data == DATA_W'(CMD_FWD))  kind = K_FWD_ARM;
      else if (data == DATA_W'(CMD_QRY))  kind = K_QUERY;
      else if (data == DATA_W'(CMD_NIB))  kind = K_NIBBLE;
      else if (data == DATA_W'(CMD_EXIT)) kind = K_EXIT;
      else kind = K_NONE; // R10 unknown values
    end
  end
endmodule

// File: rtl/nds_nibble_unit.sv
module nds_nibble_unit
  import nds_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  kind_t             kind,
  input  logic              rx_pending,
  input  logic [DATA_W-1:0] rx_data,
  output logic [DATA_W-1:0] rdback,
  output logic              rx_pop
);
  localparam int NIB_W = DATA_W / 2;
  localparam logic [NIB_W-1:0] PAD = {NIB_W{1'b1}};
  localparam logic [DATA_W-1:0] EMPTY_CODE = {{NIB_W{1'b0}}, PAD};

  logic              high_next;
  logic [DATA_W-1:0] held;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdback    <= '0;
      rx_pop    <= 1'b0;
      high_next <= 1'b0;
      held      <= '0;
    end else begin
      rx_pop <= 1'b0;
      case (kind)
        K_QUERY: rdback <= {{(DATA_W-1){1'b0}}, rx_pending};
        K_NIBBLE: begin
          if (high_next) begin
            rdback    <= {held[DATA_W-1:NIB_W], PAD};
            rx_pop    <= 1'b1;
            high_next <= 1'b0;
          end else if (rx_pending) begin
            rdback    <= {rx_data[NIB_W-1:0], PAD};
            held      <= rx_data;
            high_next <= 1'b1;
          end else begin
            rdback <= EMPTY_CODE;
          end
        end
        K_EXIT: high_next <= 1'b0;
        default: ;
      endcase
    end
  end

  AST_NIB_PADDED: assert property (@(posedge clk) disable iff (rst)
    (kind == K_NIBBLE) |=> (rdback[NIB_W-1:0] == PAD)); // R11
  AST_POP_AFTER_HIGH: assert property (@(posedge clk) disable iff (rst)
    rx_pop |-> $past(kind == K_NIBBLE) && $past(high_next)); // R6
  AST_EMPTY_NO_POP: assert property (@(posedge clk) disable iff (rst)
    (kind == K_NIBBLE && !high_next && !rx_pending) |=> !rx_pop); // R7
endmodule

// File: rtl/nds_tx_slot.sv
module nds_tx_slot #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data
);
  logic busy;
  assign busy = tx_valid && !tx_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else if (load && !busy) begin
      tx_valid <= 1'b1;
      tx_data  <= load_data;
    end else if (tx_ready) begin
      tx_valid <= 1'b0;
    end
  end

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R3
endmodule

// File: rtl/nds_stream_port.sv
module nds_stream_port
  import nds_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CMD_FWD  = 1,
  parameter int CMD_QRY  = 2,
  parameter int CMD_NIB  = 3,
  parameter int CMD_EXIT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_data,
  input  logic              rx_pending,
  input  logic [DATA_W-1:0] rx_data,
  output logic              rx_pop,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic [DATA_W-1:0] rdback,
  output logic              exit_pulse
);
  kind_t kind;
  logic  armed;

  nds_cmd_decode #(
    .DATA_W(DATA_W), .CMD_FWD(CMD_FWD), .CMD_QRY(CMD_QRY),
    .CMD_NIB(CMD_NIB), .CMD_EXIT(CMD_EXIT)
  ) u_dec (
    .wr(host_wr), .armed(armed), .data(host_data), .kind(kind)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      armed      <= 1'b0;
      exit_pulse <= 1'b0;
    end else begin
      exit_pulse <= (kind == K_EXIT);
      if (kind == K_FWD_ARM) armed <= 1'b1;
      else if (kind == K_PAYLOAD) armed <= 1'b0;
    end
  end

  nds_nibble_unit #(.DATA_W(DATA_W)) u_nib (
    .clk(clk), .rst(rst), .kind(kind), .rx_pending(rx_pending),
    .rx_data(rx_data), .rdback(rdback), .rx_pop(rx_pop)
  );

  nds_tx_slot #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst(rst), .load(kind == K_PAYLOAD), .load_data(host_data),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data)
  );

  AST_RDBK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !host_wr |=> $stable(rdback)); // R8
  AST_EXIT_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    exit_pulse |-> $past(host_wr) && $stable(rdback)); // R9
  AST_POP_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    rx_pop |-> $past(host_wr)); // R6
  AST_PAYLOAD_NO_RDBK: assert property (@(posedge clk) disable iff (rst)
    (host_wr && armed) |=> $stable(rdback) && !exit_pulse); // R2
endmodule

// File: tb/sim_nds_stream_port.sv
module sim_nds_stream_port;
  logic       clk = 0, rst = 1;
  logic       host_wr = 0, rx_pending = 0, tx_ready = 1;
  logic [7:0] host_data = 0, rx_data = 0;
  logic       rx_pop, tx_valid, exit_pulse;
  logic [7:0] tx_data, rdback;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  nds_stream_port u0 (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_data(host_data),
    .rx_pending(rx_pending), .rx_data(rx_data), .rx_pop(rx_pop),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .rdback(rdback), .exit_pulse(exit_pulse)
  );

  // {cmd, pending, rx byte, expected readback, expected pop}
  localparam logic [25:0] VEC [10] = '{
    {8'h02, 1'b0, 8'h00, 8'h00, 1'b0},  // R4 none pending
    {8'h02, 1'b1, 8'hA5, 8'h01, 1'b0},  // R4 pending
    {8'h03, 1'b1, 8'hA5, 8'h5F, 1'b0},  // R5 low nibble
    {8'h03, 1'b1, 8'hA5, 8'hAF, 1'b1},  // R6 high nibble + pop
    {8'h03, 1'b0, 8'h00, 8'h0F, 1'b0},  // R7 empty
    {8'h03, 1'b0, 8'h00, 8'h0F, 1'b0},  // R7 empty again
    {8'h03, 1'b1, 8'h00, 8'h0F, 1'b0},  // R11 zero low nibble
    {8'h03, 1'b1, 8'h00, 8'h0F, 1'b1},  // R11 zero high nibble
    {8'h07, 1'b1, 8'h3C, 8'h0F, 1'b0},  // R10 unknown ignored
    {8'h02, 1'b1, 8'h3C, 8'h01, 1'b0}   // R4 again
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    host_wr = 1; host_data = d;
    @(negedge clk);
    host_wr = 0;
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 rdback", rdback, 8'h00);
    chk("R1 flags", {5'd0, tx_valid, rx_pop, exit_pulse}, 8'h00);

    for (int i = 0; i < 10; i++) begin
      rx_pending = VEC[i][17];
      rx_data = VEC[i][16:9];
      wr(VEC[i][25:18]);
      chk($sformatf("R4-R7/R10/R11 vec%0d rdback", i), rdback, VEC[i][8:1]);
      chk($sformatf("R6 vec%0d pop", i), {7'd0, rx_pop}, {7'd0, VEC[i][0]});
      chk("R10 no tx/exit", {6'd0, tx_valid, exit_pulse}, 8'h00);
    end

    repeat (5) @(negedge clk);
    chk("R8 hold", rdback, 8'h01);

    // R2 forward a command-valued byte while transmitter stalls
    tx_ready = 0;
    wr(8'h01);
    chk("R2 arm no tx", {7'd0, tx_valid}, 8'h00);
    wr(8'h04);
    chk("R2 tx_valid", {7'd0, tx_valid}, 8'h01);
    chk("R2 tx_data", tx_data, 8'h04);
    chk("R2 no exit", {7'd0, exit_pulse}, 8'h00);
    chk("R2 rdback", rdback, 8'h01);
    repeat (3) @(negedge clk);
    chk("R3 held", tx_data, 8'h04);
    wr(8'h01);
    wr(8'h77);
    chk("R3 drop", tx_data, 8'h04);
    chk("R3 still valid", {7'd0, tx_valid}, 8'h01);
    tx_ready = 1;
    @(negedge clk);
    chk("R3 accepted", {7'd0, tx_valid}, 8'h00);

    // R9 exit restarts nibble phase
    rx_pending = 1; rx_data = 8'h5A;
    wr(8'h03);
    chk("R5 low 5A", rdback, 8'hAF);
    wr(8'h04);
    chk("R9 exit pulse", {7'd0, exit_pulse}, 8'h01);
    chk("R9 rdback kept", rdback, 8'hAF);
    @(negedge clk);
    chk("R9 pulse ends", {7'd0, exit_pulse}, 8'h00);
    wr(8'h03);
    chk("R9 phase restart", rdback, 8'hAF);
    chk("R9 no pop", {7'd0, rx_pop}, 8'h00);
    wr(8'h03);
    chk("R6 high 5A", rdback, 8'h5F);
    chk("R6 pop", {7'd0, rx_pop}, 8'h01);
    @(negedge clk);
    chk("R6 pop one cycle", {7'd0, rx_pop}, 8'h00);

    rst = 1;
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 re-reset", rdback, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule